// File: doc/BRIEF.md
# Bucket-Partitioned Receive Message Queue

This block is the receive-side store of one station on an on-chip message ring. A single 256-slot buffer is divided at run time into as many as eight independent circular queues ("buckets"). Every incoming message names its destination bucket and the ID of the station that sent it. The local consumer pops from any bucket it chooses. Each pop returns a credit, tagged with the sender's ID, in the same cycle, so the sender can refill its send allowance.

Software writes a size into a shadow register for each bucket and then issues an apply pulse. The apply is accepted only while every bucket is empty. When it is accepted, the shadow sizes become active and every pointer is cleared. Each bucket's region starts where the regions of the lower-numbered buckets end. The block checks that the active layout is legal and reports an illegal layout on a status output.

Top module: `msg_bucket_rxq`

## Requirements
- R1: After reset every bucket has size 0, `nonempty` is 0 and `config_error` is 0. A write to any bucket is then dropped and flagged as misdirected.
- R2: The region of bucket b starts at the sum of the active sizes of buckets 0..b-1. Entries pushed into a bucket come out of that bucket in push order, and no other bucket's traffic changes them.
- R3: `config_error` is high while any of the following holds: an active size is neither zero nor a power of two; a nonzero-size bucket starts at an index that is not a multiple of its size; or the sizes sum to more than 256. For example, sizes 32,32,32,64 place bucket 3 at 96, which is illegal.
- R4: A write to a bucket of size 0, a write while `config_error` is high, or a write in the cycle of an accepted apply is dropped. `wr_misdirect` is then high for one cycle, in the cycle after the write.
- R5: A write to a bucket that holds as many entries as its size is dropped, and the bucket's contents are unchanged. `wr_overflow` is then high for one cycle, in the cycle after the write.
- R6: While `rd_en` is high and bucket `rd_bkt` is non-empty, the block behaves as follows in the same cycle: `rd_valid` and `credit_valid` are high, `rd_data` is the oldest entry of that bucket, and `credit_sid` is that entry's sender ID. The entry is removed at the next clock edge.
- R7: A pop from an empty bucket changes nothing. It gives no `rd_valid` and no credit, and `rd_underflow` is high in the following cycle.
- R8: Bit b of `nonempty` is high exactly when bucket b holds at least one entry, as updated at each clock edge.
- R9: An apply while any bucket is non-empty is ignored. The old layout and the old contents remain.
- R10: Read and write positions wrap inside the bucket's own region, so traffic longer than the size keeps its order. This holds in the region that ends at slot 255.
- R11: A push and a pop on the same non-empty, non-full bucket in one cycle both take effect, and the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write `cfg_size` into the shadow size of `cfg_bkt` |
| cfg_bkt | input | 3 | Bucket selected for a shadow size write |
| cfg_size | input | 9 | Bucket size, 0 to 256 |
| cfg_apply | input | 1 | Make the shadow sizes active and clear pointers (only when all buckets are empty) |
| config_error | output | 1 | The active layout breaks the size, alignment or total rule |
| wr_en | input | 1 | Incoming message strobe |
| wr_bkt | input | 3 | Destination bucket |
| wr_sid | input | 6 | Sender station ID |
| wr_data | input | 32 | Message payload |
| wr_overflow | output | 1 | Previous write hit a full bucket and was dropped |
| wr_misdirect | output | 1 | Previous write targeted an unusable bucket and was dropped |
| rd_en | input | 1 | Pop request |
| rd_bkt | input | 3 | Bucket to pop |
| rd_valid | output | 1 | The pop is taking place this cycle |
| rd_data | output | 32 | Payload of the popped entry |
| rd_underflow | output | 1 | Previous pop hit an empty bucket |
| credit_valid | output | 1 | Credit return strobe |
| credit_sid | output | 6 | Station that receives the credit |
| nonempty | output | 8 | Per-bucket non-empty status |

## Verification
The hardest state to reach is a bucket whose pointers have wrapped while it shares the buffer with full neighbours. A wrap there is the point where an addressing error would corrupt another region. The stimulus first fills every bucket of a power-of-two layout to its limit and attempts an apply that must be refused. It then drains everything, applies a second layout, parks a marker entry in bucket 0 and runs more simultaneous push/pop rounds on bucket 1 than the bucket holds. Finally it fills the 128-slot region that ends at the last buffer slot.

// File: rtl/mbq_pkg.sv
package mbq_pkg;
    parameter int unsigned SID_W  = 6;
    parameter int unsigned DATA_W = 32;

    typedef struct packed {
        logic [SID_W-1:0]  sid;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_STORE,
        WR_FULL,
        WR_BADBKT
    } wr_verdict_e;

    function automatic logic pow2_or_zero(input logic [31:0] v);
        return (v & (v - 32'd1)) == 32'd0;
    endfunction
endpackage

// File: rtl/mbq_layout.sv
module mbq_layout #(
    parameter int DEPTH = 256,
    parameter int NBKT  = 8,
    parameter int CW    = 9
) (
    input  logic [CW-1:0] size_i [NBKT],
    output logic [CW-1:0] base_o [NBKT],
    output logic          bad_o
);
    logic [31:0] run;

    always_comb begin
        run   = 32'd0;
        bad_o = 1'b0;
        for (int b = 0; b < NBKT; b++) begin
            base_o[b] = CW'(run);
            if (!mbq_pkg::pow2_or_zero(32'(size_i[b])))
                bad_o = 1'b1;
            if (size_i[b] != '0 && ((run & (32'(size_i[b]) - 32'd1)) != 32'd0))
                bad_o = 1'b1;
            run = run + 32'(size_i[b]);
        end
        if (run > 32'(DEPTH))
            bad_o = 1'b1;
    end
endmodule

// File: rtl/mbq_bucket_ctl.sv
module mbq_bucket_ctl #(
    parameter int AW = 8,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [CW-1:0] size,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] head,
    output logic [AW-1:0] tail,
    output logic [CW-1:0] fill
);
    function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [CW-1:0] sz);
        return AW'((CW'(p) + CW'(1)) & (sz - CW'(1)));
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head <= '0;
            tail <= '0;
            fill <= '0;
        end else begin
            if (push)
                tail <= step(tail, size);
            if (pop)
                head <= step(head, size);
            if (push && !pop)
                fill <= fill + CW'(1);
            else if (pop && !push)
                fill <= fill - CW'(1);
        end
    end
endmodule

// File: rtl/mbq_store.sv
module mbq_store #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic           clk,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  mbq_pkg::slot_t wslot,
    input  logic [AW-1:0]  raddr,
    output mbq_pkg::slot_t rslot
);
    mbq_pkg::slot_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wslot;
    end

    assign rslot = mem[raddr];
endmodule

// File: rtl/msg_bucket_rxq.sv
module msg_bucket_rxq #(
    parameter int DEPTH = 256,
    parameter int NBKT  = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int BW   = $clog2(NBKT)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [BW-1:0]              cfg_bkt,
    input  logic [CW-1:0]              cfg_size,
    input  logic                       cfg_apply,
    output logic                       config_error,
    input  logic                       wr_en,
    input  logic [BW-1:0]              wr_bkt,
    input  logic [mbq_pkg::SID_W-1:0]  wr_sid,
    input  logic [mbq_pkg::DATA_W-1:0] wr_data,
    output logic                       wr_overflow,
    output logic                       wr_misdirect,
    input  logic                       rd_en,
    input  logic [BW-1:0]              rd_bkt,
    output logic                       rd_valid,
    output logic [mbq_pkg::DATA_W-1:0] rd_data,
    output logic                       rd_underflow,
    output logic                       credit_valid,
    output logic [mbq_pkg::SID_W-1:0]  credit_sid,
    output logic [NBKT-1:0]            nonempty
);
    import mbq_pkg::*;

    logic [CW-1:0] shadow_sz [NBKT];
    logic [CW-1:0] active_sz [NBKT];
    logic [CW-1:0] base      [NBKT];
    logic [CW-1:0] fill      [NBKT];
    logic [AW-1:0] head      [NBKT];
    logic [AW-1:0] tail      [NBKT];
    logic [NBKT-1:0] has_data, is_full, push_v, pop_v;
    logic cfg_bad, do_apply, pop_ok;
    wr_verdict_e verdict;
    slot_t rslot;

    assign do_apply = cfg_apply && (has_data == '0);

    // Shadow and active size registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBKT; b++) begin
                shadow_sz[b] <= '0;
                active_sz[b] <= '0;
            end
        end else begin
            if (cfg_we)
                shadow_sz[cfg_bkt] <= cfg_size;
            if (do_apply)
                for (int b = 0; b < NBKT; b++)
                    active_sz[b] <= shadow_sz[b];
        end
    end

    mbq_layout #(.DEPTH(DEPTH), .NBKT(NBKT), .CW(CW)) u_layout (
        .size_i (active_sz),
        .base_o (base),
        .bad_o  (cfg_bad)
    );

    // Per-bucket pointer and fill state
    for (genvar b = 0; b < NBKT; b++) begin : g_bkt
        mbq_bucket_ctl #(.AW(AW), .CW(CW)) u_ctl (
            .clk   (clk),
            .rst   (rst),
            .clear (do_apply),
            .size  (active_sz[b]),
            .push  (push_v[b]),
            .pop   (pop_v[b]),
            .head  (head[b]),
            .tail  (tail[b]),
            .fill  (fill[b])
        );
        assign has_data[b] = fill[b] != '0;
        assign is_full[b]  = fill[b] == active_sz[b];
    end

    // Write admission
    always_comb begin
        if (!wr_en)
            verdict = WR_IDLE;
        else if (cfg_bad || do_apply || active_sz[wr_bkt] == '0)
            verdict = WR_BADBKT;
        else if (is_full[wr_bkt])
            verdict = WR_FULL;
        else
            verdict = WR_STORE;
    end

    assign pop_ok = rd_en && has_data[rd_bkt];
    assign push_v = (verdict == WR_STORE) ? (NBKT'(1) << wr_bkt) : '0;
    assign pop_v  = pop_ok ? (NBKT'(1) << rd_bkt) : '0;

    mbq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (verdict == WR_STORE),
        .waddr (AW'(base[wr_bkt] + CW'(tail[wr_bkt]))),
        .wslot ('{sid: wr_sid, data: wr_data}),
        .raddr (AW'(base[rd_bkt] + CW'(head[rd_bkt]))),
        .rslot (rslot)
    );

    // Registered error pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_overflow  <= 1'b0;
            wr_misdirect <= 1'b0;
            rd_underflow <= 1'b0;
        end else begin
            wr_overflow  <= verdict == WR_FULL;
            wr_misdirect <= verdict == WR_BADBKT;
            rd_underflow <= rd_en && !has_data[rd_bkt];
        end
    end

    assign config_error = cfg_bad;
    assign nonempty     = has_data;
    assign rd_valid     = pop_ok;
    assign credit_valid = pop_ok;
    assign rd_data      = rslot.data;
    assign credit_sid   = rslot.sid;
endmodule

// File: rtl/mbq_chk.sv
module mbq_chk #(
    parameter int NBKT = 8,
    parameter int CW   = 9,
    localparam int BW  = $clog2(NBKT)
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic            rd_en,
    input logic [BW-1:0]   rd_bkt,
    input logic            cfg_apply,
    input logic            config_error,
    input logic            wr_overflow,
    input logic            wr_misdirect,
    input logic            rd_underflow,
    input logic            credit_valid,
    input logic [NBKT-1:0] nonempty,
    input logic [CW-1:0]   fill      [NBKT],
    input logic [CW-1:0]   active_sz [NBKT]
);
    // R7
    underflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && !nonempty[rd_bkt] |=> rd_underflow);

    // R7
    credit_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        credit_valid |-> nonempty[rd_bkt]);

    // R9
    apply_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_apply && nonempty == '0 |=> nonempty == '0);

    // R5
    overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wr_overflow |-> $past(wr_en));

    // R4
    drop_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_overflow && wr_misdirect));

    // R3
    config_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_apply) |-> $stable(config_error));

    for (genvar b = 0; b < NBKT; b++) begin : g_fill
        // R8
        fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
            fill[b] <= active_sz[b]);
    end
endmodule

bind msg_bucket_rxq mbq_chk #(.NBKT(NBKT), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_bkt       (rd_bkt),
    .cfg_apply    (cfg_apply),
    .config_error (config_error),
    .wr_overflow  (wr_overflow),
    .wr_misdirect (wr_misdirect),
    .rd_underflow (rd_underflow),
    .credit_valid (credit_valid),
    .nonempty     (nonempty),
    .fill         (fill),
    .active_sz    (active_sz)
);

// File: tb/msg_bucket_rxq_test.sv
module msg_bucket_rxq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_apply = 1'b0;
    logic [2:0]  cfg_bkt = '0;
    logic [8:0]  cfg_size = '0;
    logic        config_error;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_bkt = '0;
    logic [5:0]  wr_sid = '0;
    logic [31:0] wr_data = '0;
    logic        wr_overflow, wr_misdirect;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_bkt = '0;
    logic        rd_valid, rd_underflow, credit_valid;
    logic [31:0] rd_data;
    logic [5:0]  credit_sid;
    logic [7:0]  nonempty;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    msg_bucket_rxq uut (.*);

    function automatic int exp_data(int b, int i);
        return b * 100000 + i * 3 + 7;
    endfunction

    function automatic int exp_sid(int b, int i);
        return (b * 5 + i) % 64;
    endfunction

    task automatic chk(string tag, longint act, longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic load_cfg(input int sz[8]);
        for (int b = 0; b < 8; b++) begin
            cfg_we = 1'b1; cfg_bkt = 3'(b); cfg_size = 9'(sz[b]);
            tick();
        end
        cfg_we = 1'b0;
        cfg_apply = 1'b1;
        tick();
        cfg_apply = 1'b0;
    endtask

    task automatic push(int b, int i);
        wr_en = 1'b1; wr_bkt = 3'(b);
        wr_sid = 6'(exp_sid(b, i)); wr_data = 32'(exp_data(b, i));
        tick();
        wr_en = 1'b0;
    endtask

    task automatic check_pop_outputs(int b, int i, string tag);
        chk({tag, " rd_valid"}, rd_valid, 1);
        chk({tag, " rd_data"}, rd_data, exp_data(b, i));
        chk({tag, " credit_valid"}, credit_valid, 1);
        chk({tag, " credit_sid"}, credit_sid, exp_sid(b, i));
    endtask

    task automatic pop(int b, int i, string tag);
        rd_en = 1'b1; rd_bkt = 3'(b);
        #1;
        check_pop_outputs(b, i, tag);
        @(posedge clk); #1;
        rd_en = 1'b0;
        chk({tag, " no underflow"}, rd_underflow, 0);
    endtask

    task automatic pop_empty(int b);
        rd_en = 1'b1; rd_bkt = 3'(b);
        #1;
        chk("R7 rd_valid on empty", rd_valid, 0);
        chk("R7 credit on empty", credit_valid, 0);
        @(posedge clk); #1;
        rd_en = 1'b0;
        chk("R7 rd_underflow", rd_underflow, 1);
    endtask

    initial begin
        int cfg_p[8] = '{1, 1, 2, 4, 8, 16, 32, 64};
        int cfg_a[8] = '{32, 32, 64, 128, 0, 0, 0, 0};
        int bad_align[8] = '{32, 32, 32, 64, 0, 0, 0, 0};
        int bad_pow[8]   = '{48, 0, 0, 0, 0, 0, 0, 0};
        int bad_sum[8]   = '{128, 128, 4, 0, 0, 0, 0, 0};

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        tick();
        chk("R1 nonempty after reset", nonempty, 0);
        chk("R1 config_error after reset", config_error, 0);
        push(0, 0);
        chk("R1 misdirect on size-0 bucket", wr_misdirect, 1);
        chk("R1 nothing stored", nonempty, 0);

        // Power-of-two layout: fill every bucket to its limit
        load_cfg(cfg_p);
        chk("R3 legal layout", config_error, 0);
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < cfg_p[b]; i++) begin
                push(b, i);
                chk("R5 no overflow below size", wr_overflow, 0);
            end
            chk("R8 nonempty bit set", nonempty[b], 1);
            push(b, 999);
            chk("R5 overflow when full", wr_overflow, 1);
        end
        chk("R8 all nonempty", nonempty, 8'hFF);

        // Refused apply while data is held
        load_cfg(cfg_a);
        chk("R9 refused apply keeps data", nonempty, 8'hFF);
        chk("R9 refused apply keeps layout", config_error, 0);

        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < cfg_p[b]; i++)
                pop(b, i, "R2 R6 drain");
            chk("R8 nonempty bit clear", nonempty[b], 0);
            pop_empty(b);
        end

        // Second layout from shadow (sizes 32,32,64,128)
        cfg_apply = 1'b1; tick(); cfg_apply = 1'b0;
        chk("R3 layout A legal", config_error, 0);
        push(4, 0);
        chk("R4 misdirect to size-0 bucket", wr_misdirect, 1);
        chk("R4 nothing stored", nonempty, 0);

        push(0, 500);
        push(1, 0);
        for (int i = 1; i <= 40; i++) begin
            wr_en = 1'b1; wr_bkt = 3'd1;
            wr_sid = 6'(exp_sid(1, i)); wr_data = 32'(exp_data(1, i));
            rd_en = 1'b1; rd_bkt = 3'd1;
            #1;
            check_pop_outputs(1, i - 1, "R10 R11 wrap");
            @(posedge clk); #1;
            wr_en = 1'b0; rd_en = 1'b0;
            chk("R11 no overflow on push+pop", wr_overflow, 0);
            chk("R11 still nonempty", nonempty[1], 1);
        end
        pop(1, 40, "R10 last");
        chk("R11 bucket1 empty", nonempty[1], 0);
        pop(0, 500, "R2 isolation marker");

        for (int i = 0; i < 128; i++)
            push(3, i);
        push(3, 777);
        chk("R5 top region overflow", wr_overflow, 1);
        for (int i = 0; i < 128; i++)
            pop(3, i, "R10 top region");
        chk("R8 all empty", nonempty, 0);

        // Illegal layouts
        load_cfg(bad_align);
        chk("R3 misaligned start", config_error, 1);
        push(0, 1);
        chk("R4 misdirect under config_error", wr_misdirect, 1);
        chk("R4 nothing stored under error", nonempty, 0);
        load_cfg(bad_pow);
        chk("R3 non power of two", config_error, 1);
        load_cfg(bad_sum);
        chk("R3 sum over 256", config_error, 1);
        load_cfg(cfg_a);
        chk("R3 error clears", config_error, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule